// File: doc/BRIEF.md
# Auto-Acknowledging Prioritized Interrupt Controller

This block gathers a parameterised set of level-sensitive interrupt lines and hands them out to a small group of processors. Each line has a mask bit, a software-trigger bit and a routing bitmap that selects which processors may take it. A line is pending while its input is high or its software bit is set. It is live when it is pending and unmasked. Each processor sees one interrupt output. That output stays high while any live line is routed to that processor.

Software reaches the controller over a simple word-addressed register bus. The bus carries the index of the processor that makes each access. When a processor reads the event register, it gets back the lowest-numbered live line routed to it. The same read masks that line, so the line stays quiet until its handler unmasks it again. Masks and software triggers are changed through separate set and clear banks, so no read-modify-write sequence is needed.

Top module: `irq_event_ctrl`

## Requirements
- R1: After reset every mask bit is 1, every software bit is 0, every routing register holds 1 (processor 0 only), `cpu_irq` is all zero and `bus_rdata` is 0.
- R2: A read of byte offset 0x000 returns the number of implemented lines in bits [15:0] and zeros above.
- R3: Mask word w is written at 0x100+4w (a 1 sets the bit) and at 0x180+4w (a 1 clears the bit). Bit b of word w belongs to line 32w+b, and 0 bits in the write data leave their lines unchanged. A read of either address returns the current mask word.
- R4: Software-trigger word w is written at 0x200+4w (a 1 sets the bit) and at 0x280+4w (a 1 clears the bit), with the same bit layout as R3. A read of either address returns the current trigger word. A line is pending when its input is high or its trigger bit is set.
- R5: The routing register of line L is at 0x1000+4L. Bits [N_CPUS-1:0] form a processor bitmap and a read returns it. A line is offered only to the processors whose bit is set.
- R6: A read of offset 0x004 made with `bus_cpu` = c returns, on `bus_rdata` in the cycle after the strobe, {8'h00, 8'h01, 16-bit line number} for the chosen live line routed to c. It returns 0 when no such line exists.
- R7: An event read that returns a line sets that line's mask bit at the same clock edge. A following event read from any processor does not return that line again until it is unmasked, even when the two reads come from different processors on consecutive cycles.
- R8: `cpu_irq[c]` is registered. In each cycle it shows whether, one cycle earlier, any live line was routed to processor c.
- R9: Lines are level-sensitive. When an input falls while its trigger bit is clear, the line stops being pending at once, with no acknowledge.
- R10: When several live lines are routed to the reading processor, the lowest-numbered one is returned.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_cpu | input | CPU_W | Index of the processor making the access |
| bus_addr | input | 16 | Byte address of the access |
| bus_wen | input | 1 | Write strobe |
| bus_ren | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_ren` and 0 otherwise |
| hw_irq | input | N_LINES | Level-sensitive interrupt inputs |
| cpu_irq | output | N_CPUS | Per-processor interrupt request |

## Verification
On every cycle the assertions check the shape of each event word. They also check that an event read finds nothing when no live line was routed to the reader, that the returned line was the lowest live one for that processor, and that it is masked afterwards. In addition they check that all processor outputs stay low when every line is masked. Only the bench scenarios can show the effects that depend on particular register contents. These are routing to a chosen processor, the lowest-wins order between two real inputs, two processors racing for one shared line, a level dropping before service, and the exact bit placement of the set and clear banks.

// File: rtl/irq_ctrl_pkg.sv
// Shared constants for the interrupt event controller.
// Assumes a 16-bit byte address and 32-bit data words.
package irq_ctrl_pkg;
    localparam logic [15:0] A_INFO  = 16'h0000;
    localparam logic [15:0] A_EVENT = 16'h0004;
    localparam logic [15:0] A_MSET  = 16'h0100;
    localparam logic [15:0] A_MCLR  = 16'h0180;
    localparam logic [15:0] A_SSET  = 16'h0200;
    localparam logic [15:0] A_SCLR  = 16'h0280;
    localparam logic [15:0] A_ROUTE = 16'h1000;

    localparam logic [7:0] EV_KIND_HW = 8'h01;

    typedef struct packed {
        logic [7:0]  die;
        logic [7:0]  kind;
        logic [15:0] line;
    } event_word_t;
endpackage

// File: rtl/irq_line_bank.sv
// Per-line mask and software-trigger state.
// Assumes that at most one bank strobe is active per cycle. An acknowledge
// always forces the mask on and wins over any mask write.
module irq_line_bank #(
    parameter int N_LINES = 64,
    localparam int LINE_W = $clog2(N_LINES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mset_we,
    input  logic               mclr_we,
    input  logic               sset_we,
    input  logic               sclr_we,
    input  logic [4:0]         word_sel,
    input  logic [31:0]        wdata,
    input  logic               ack_we,
    input  logic [LINE_W-1:0]  ack_line,
    output logic [N_LINES-1:0] mask_q,
    output logic [N_LINES-1:0] swt_q
);
    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        localparam int WORD = i / 32;
        localparam int BIT  = i % 32;
        logic hit;
        logic m_q;
        logic s_q;

        // Does this write touch this line's bit?
        assign hit = (word_sel == 5'(WORD)) && wdata[BIT];

        // Mask bit: reset masked, acknowledge masks, then set and clear writes.
        always_ff @(posedge clk) begin
            if (!rst_n)                                  m_q <= 1'b1;
            else if (ack_we && ack_line == LINE_W'(i))   m_q <= 1'b1;
            else if (mset_we && hit)                     m_q <= 1'b1;
            else if (mclr_we && hit)                     m_q <= 1'b0;
        end

        // Software-trigger bit: reset clear, then set and clear writes.
        always_ff @(posedge clk) begin
            if (!rst_n)               s_q <= 1'b0;
            else if (sset_we && hit)  s_q <= 1'b1;
            else if (sclr_we && hit)  s_q <= 1'b0;
        end

        assign mask_q[i] = m_q;
        assign swt_q[i]  = s_q;
    end
endmodule

// File: rtl/irq_route_table.sv
// Per-line processor routing bitmaps.
// Assumes one line is written per cycle. Every bitmap resets to processor 0.
module irq_route_table #(
    parameter int N_LINES = 64,
    parameter int N_CPUS  = 4,
    localparam int LINE_W = $clog2(N_LINES)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            we,
    input  logic [LINE_W-1:0]               line_sel,
    input  logic [N_CPUS-1:0]               wdata,
    output logic [N_LINES-1:0][N_CPUS-1:0]  route_q
);
    for (genvar i = 0; i < N_LINES; i++) begin : g_route
        logic [N_CPUS-1:0] r_q;

        // Routing register: reset to processor 0, loaded on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n)                              r_q <= N_CPUS'(1);
            else if (we && line_sel == LINE_W'(i))   r_q <= wdata;
        end

        assign route_q[i] = r_q;
    end
endmodule

// File: rtl/irq_prio_select.sv
// One fixed-priority finder per processor. The lowest-numbered live line
// routed to that processor wins. Purely combinational.
module irq_prio_select #(
    parameter int N_LINES = 64,
    parameter int N_CPUS  = 4,
    localparam int LINE_W = $clog2(N_LINES)
) (
    input  logic [N_LINES-1:0]              live,
    input  logic [N_LINES-1:0][N_CPUS-1:0]  route,
    output logic [N_CPUS-1:0]               hit,
    output logic [N_CPUS-1:0][LINE_W-1:0]   pick
);
    for (genvar c = 0; c < N_CPUS; c++) begin : g_cpu
        logic              h;
        logic [LINE_W-1:0] p;

        // Scan from the top down so the lowest index is left in p.
        always_comb begin
            h = 1'b0;
            p = '0;
            for (int i = N_LINES - 1; i >= 0; i--) begin
                if (live[i] && route[i][c]) begin
                    h = 1'b1;
                    p = LINE_W'(i);
                end
            end
        end

        assign hit[c]  = h;
        assign pick[c] = p;
    end
endmodule

// File: rtl/irq_event_ctrl.sv
// Top level of the interrupt event controller. It decodes the register bus,
// gives out and acknowledges events per processor, and registers the
// processor request lines. Assumes one bus access (read or write) per cycle
// and N_LINES <= 1024.
module irq_event_ctrl
    import irq_ctrl_pkg::*;
#(
    parameter int N_LINES = 64,
    parameter int N_CPUS  = 4,
    localparam int CPU_W  = (N_CPUS > 1) ? $clog2(N_CPUS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CPU_W-1:0]   bus_cpu,
    input  logic [15:0]        bus_addr,
    input  logic               bus_wen,
    input  logic               bus_ren,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [N_LINES-1:0] hw_irq,
    output logic [N_CPUS-1:0]  cpu_irq
);
    localparam int LINE_W = $clog2(N_LINES);
    localparam int NW     = (N_LINES + 31) / 32;

    logic [N_LINES-1:0]             mask_q;
    logic [N_LINES-1:0]             swt_q;
    logic [N_LINES-1:0]             pend;
    logic [N_LINES-1:0]             live;
    logic [N_LINES-1:0][N_CPUS-1:0] route_q;
    logic [N_CPUS-1:0]              hit;
    logic [N_CPUS-1:0][LINE_W-1:0]  pick;
    logic [NW*32-1:0]               mask_pad;
    logic [NW*32-1:0]               swt_pad;

    logic [4:0]        word_sel;
    logic              in_mset, in_mclr, in_sset, in_sclr;
    logic [15:0]       route_off;
    logic              in_route;
    logic [LINE_W-1:0] route_line;
    logic              ev_rd;
    logic              ev_hit;
    logic [LINE_W-1:0] ev_line;
    logic              ack_we;
    event_word_t       ev_word;
    logic [31:0]       rd_val;

    // True when the address falls inside the implemented words of a bank.
    function automatic logic bank_hit(input logic [15:0] a, input logic [15:0] base);
        return (a[15:7] == base[15:7]) && (a[1:0] == 2'b00) && (int'(a[6:2]) < NW);
    endfunction

    // Address decode for the banks and the routing table.
    assign word_sel   = bus_addr[6:2];
    assign in_mset    = bank_hit(bus_addr, A_MSET);
    assign in_mclr    = bank_hit(bus_addr, A_MCLR);
    assign in_sset    = bank_hit(bus_addr, A_SSET);
    assign in_sclr    = bank_hit(bus_addr, A_SCLR);
    assign route_off  = bus_addr - A_ROUTE;
    assign in_route   = (bus_addr >= A_ROUTE) && (route_off[1:0] == 2'b00)
                        && (route_off[15:2] < 14'(N_LINES));
    assign route_line = route_off[LINE_W+1:2];

    // Pending and live line vectors.
    assign pend = hw_irq | swt_q;
    assign live = pend & ~mask_q;

    irq_line_bank #(.N_LINES(N_LINES)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .mset_we  (bus_wen && in_mset),
        .mclr_we  (bus_wen && in_mclr),
        .sset_we  (bus_wen && in_sset),
        .sclr_we  (bus_wen && in_sclr),
        .word_sel (word_sel),
        .wdata    (bus_wdata),
        .ack_we   (ack_we),
        .ack_line (ev_line),
        .mask_q   (mask_q),
        .swt_q    (swt_q)
    );

    irq_route_table #(.N_LINES(N_LINES), .N_CPUS(N_CPUS)) u_route (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (bus_wen && in_route),
        .line_sel (route_line),
        .wdata    (bus_wdata[N_CPUS-1:0]),
        .route_q  (route_q)
    );

    irq_prio_select #(.N_LINES(N_LINES), .N_CPUS(N_CPUS)) u_prio (
        .live  (live),
        .route (route_q),
        .hit   (hit),
        .pick  (pick)
    );

    // Select the finder result of the processor making the access.
    always_comb begin
        ev_hit  = 1'b0;
        ev_line = '0;
        for (int c = 0; c < N_CPUS; c++) begin
            if (bus_cpu == CPU_W'(c)) begin
                ev_hit  = hit[c];
                ev_line = pick[c];
            end
        end
    end

    // An event read that finds a line acknowledges it.
    assign ev_rd  = bus_ren && (bus_addr == A_EVENT);
    assign ack_we = ev_rd && ev_hit;

    assign ev_word.die  = 8'h00;
    assign ev_word.kind = EV_KIND_HW;
    assign ev_word.line = 16'(ev_line);

    assign mask_pad = (NW*32)'(mask_q);
    assign swt_pad  = (NW*32)'(swt_q);

    // Read data multiplexer.
    always_comb begin
        rd_val = 32'h0;
        if (bus_addr == A_INFO)
            rd_val = {16'h0, 16'(N_LINES)};
        else if (ev_rd)
            rd_val = ev_hit ? ev_word : 32'h0;
        else if (in_mset || in_mclr)
            rd_val = mask_pad[32*word_sel +: 32];
        else if (in_sset || in_sclr)
            rd_val = swt_pad[32*word_sel +: 32];
        else if (in_route)
            rd_val = 32'(route_q[route_line]);
    end

    // Registered read data, zero when no read is in progress.
    always_ff @(posedge clk) begin
        if (!rst_n)       bus_rdata <= 32'h0;
        else if (bus_ren) bus_rdata <= rd_val;
        else              bus_rdata <= 32'h0;
    end

    // Registered per-processor request outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) cpu_irq <= '0;
        else        cpu_irq <= hit;
    end
endmodule

// File: rtl/irq_event_ctrl_checker.sv
// Cycle-by-cycle properties of the interrupt event controller, bound to the
// top module. It keeps its own one-cycle copy of the live lines seen by the
// reader, so that event results can be judged against them.
module irq_event_ctrl_checker
    import irq_ctrl_pkg::*;
#(
    parameter int N_LINES = 64,
    parameter int N_CPUS  = 4,
    localparam int CPU_W  = (N_CPUS > 1) ? $clog2(N_CPUS) : 1,
    localparam int LINE_W = $clog2(N_LINES)
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic [CPU_W-1:0]                bus_cpu,
    input logic [15:0]                     bus_addr,
    input logic                            bus_ren,
    input logic [31:0]                     bus_rdata,
    input logic [N_CPUS-1:0]               cpu_irq,
    input logic [N_LINES-1:0]              mask_q,
    input logic [N_LINES-1:0]              pend,
    input logic [N_LINES-1:0][N_CPUS-1:0]  route_q
);
    logic [N_LINES-1:0] elig_now;
    logic [N_LINES-1:0] elig_q;
    logic [N_LINES-1:0] below;
    logic               ev_q;
    logic [LINE_W-1:0]  line_rx;
    logic               line_ok;

    // Live lines routed to the processor now on the bus.
    always_comb begin
        for (int i = 0; i < N_LINES; i++)
            elig_now[i] = pend[i] && !mask_q[i]
                          && (int'(bus_cpu) < N_CPUS) && route_q[i][bus_cpu];
    end

    // Remember whether an event read happened and what it could see.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ev_q   <= 1'b0;
            elig_q <= '0;
        end else begin
            ev_q   <= bus_ren && (bus_addr == A_EVENT);
            elig_q <= elig_now;
        end
    end

    assign line_rx = bus_rdata[LINE_W-1:0];
    assign line_ok = bus_rdata[15:0] < 16'(N_LINES);
    assign below   = elig_q & ~({N_LINES{1'b1}} << line_rx);

    // R6: a non-zero event word carries kind 1, die 0 and a real line.
    p_event_format_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_q && bus_rdata != 32'h0) |-> (bus_rdata[31:16] == 16'h0001 && line_ok));

    // R6: nothing live for the reader gives a zero event word.
    p_empty_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_q && elig_q == '0) |-> (bus_rdata == 32'h0));

    // R10: the returned line was live for the reader, with none lower.
    p_lowest_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_q && bus_rdata != 32'h0 && line_ok) |-> (elig_q[line_rx] && below == '0));

    // R7: the returned line is masked by the time its data appears.
    p_ack_masks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_q && bus_rdata != 32'h0 && line_ok) |-> mask_q[line_rx]);

    // R8: with every line masked, no request is raised one cycle later.
    p_masked_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask_q) |=> (cpu_irq == '0));
endmodule

bind irq_event_ctrl irq_event_ctrl_checker #(.N_LINES(N_LINES), .N_CPUS(N_CPUS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_cpu   (bus_cpu),
    .bus_addr  (bus_addr),
    .bus_ren   (bus_ren),
    .bus_rdata (bus_rdata),
    .cpu_irq   (cpu_irq),
    .mask_q    (mask_q),
    .pend      (pend),
    .route_q   (route_q)
);

// File: tb/irq_event_ctrl_test.sv
`timescale 1ns/1ps
// Directed bench for the interrupt event controller, one task per scenario.
module irq_event_ctrl_test;
    localparam int N_LINES = 64;
    localparam int N_CPUS  = 4;
    localparam int CPU_W   = 2;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [CPU_W-1:0]   bus_cpu = '0;
    logic [15:0]        bus_addr = '0;
    logic               bus_wen = 1'b0;
    logic               bus_ren = 1'b0;
    logic [31:0]        bus_wdata = '0;
    logic [31:0]        bus_rdata;
    logic [N_LINES-1:0] hw_irq = '0;
    logic [N_CPUS-1:0]  cpu_irq;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    irq_event_ctrl #(.N_LINES(N_LINES), .N_CPUS(N_CPUS)) uut (
        .clk(clk), .rst_n(rst_n), .bus_cpu(bus_cpu), .bus_addr(bus_addr),
        .bus_wen(bus_wen), .bus_ren(bus_ren), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .hw_irq(hw_irq), .cpu_irq(cpu_irq)
    );

    always #4 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
        @(negedge clk);
        bus_wen = 1'b0;
    endtask

    task automatic rd(input int cpu, input logic [15:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_cpu = CPU_W'(cpu); bus_addr = a; bus_ren = 1'b1;
        @(negedge clk);
        d = bus_rdata; bus_ren = 1'b0;
    endtask

    task automatic irq_is(input string req, input logic [N_CPUS-1:0] exp);
        @(negedge clk);
        check(req, 32'(cpu_irq), 32'(exp));
    endtask

    task automatic t_reset;
        logic [31:0] d;
        check("R1 cpu_irq", 32'(cpu_irq), 32'h0);
        check("R1 rdata", bus_rdata, 32'h0);
        rd(0, 16'h0000, d); check("R2 info", d, 32'h0000_0040);
        rd(0, 16'h0004, d); check("R1 event empty", d, 32'h0);
        rd(0, 16'h0100, d); check("R1 mask w0", d, 32'hffff_ffff);
        rd(0, 16'h0184, d); check("R1 mask w1", d, 32'hffff_ffff);
        rd(0, 16'h0200, d); check("R1 swt w0", d, 32'h0);
        rd(0, 16'h1000, d); check("R1 route 0", d, 32'h1);
        rd(0, 16'h10fc, d); check("R1 route 63", d, 32'h1);
    endtask

    task automatic t_mask_bank;
        logic [31:0] d;
        wr(16'h0184, 32'h0000_00f0);
        rd(0, 16'h0184, d); check("R3 clear bits", d, 32'hffff_ff0f);
        rd(0, 16'h0100, d); check("R3 other word kept", d, 32'hffff_ffff);
        wr(16'h0104, 32'h0000_0030);
        rd(0, 16'h0104, d); check("R3 set bits", d, 32'hffff_ff3f);
        wr(16'h0104, 32'h0000_00c0);
        rd(0, 16'h0184, d); check("R3 restored", d, 32'hffff_ffff);
    endtask

    task automatic t_soft_trigger;
        logic [31:0] d;
        wr(16'h0180, 32'h0000_0020);           // unmask line 5
        wr(16'h0200, 32'h0000_0020);           // trigger line 5
        rd(0, 16'h0200, d); check("R4 swt set", d, 32'h0000_0020);
        irq_is("R8 irq from soft line", 4'b0001);
        rd(0, 16'h0004, d); check("R6 event line 5", d, 32'h0001_0005);
        rd(0, 16'h0100, d); check("R7 auto mask", d, 32'hffff_ffff);
        irq_is("R7 irq after ack", 4'b0000);
        rd(0, 16'h0004, d); check("R7 no repeat", d, 32'h0);
        wr(16'h0280, 32'h0000_0020);
        rd(0, 16'h0280, d); check("R4 swt clear", d, 32'h0);
    endtask

    task automatic t_priority;
        logic [31:0] d;
        hw_irq[40] = 1'b1; hw_irq[7] = 1'b1;
        wr(16'h0180, 32'h0000_0080);           // unmask line 7
        wr(16'h0184, 32'h0000_0100);           // unmask line 40
        rd(0, 16'h0004, d); check("R10 lowest first", d, 32'h0001_0007);
        rd(0, 16'h0004, d); check("R10 next line", d, 32'h0001_0028);
        rd(0, 16'h0004, d); check("R7 all taken", d, 32'h0);
        hw_irq[40] = 1'b0; hw_irq[7] = 1'b0;
    endtask

    task automatic t_routing;
        logic [31:0] d;
        wr(16'h1084, 32'h0000_0004);           // line 33 to processor 2
        rd(0, 16'h1084, d); check("R5 route readback", d, 32'h4);
        wr(16'h0184, 32'h0000_0002);           // unmask line 33
        hw_irq[33] = 1'b1;
        irq_is("R5 only cpu2 raised", 4'b0100);
        rd(0, 16'h0004, d); check("R5 cpu0 sees nothing", d, 32'h0);
        rd(2, 16'h0004, d); check("R5 cpu2 gets 33", d, 32'h0001_0021);
        irq_is("R7 cpu2 quiet", 4'b0000);
        hw_irq[33] = 1'b0;
    endtask

    task automatic t_shared_race;
        logic [31:0] d0, d1;
        wr(16'h100c, 32'h0000_0003);           // line 3 to processors 0 and 1
        wr(16'h0180, 32'h0000_0008);
        wr(16'h0200, 32'h0000_0008);
        irq_is("R5 both raised", 4'b0011);
        @(negedge clk);
        bus_cpu = 2'd0; bus_addr = 16'h0004; bus_ren = 1'b1;
        @(negedge clk);
        d0 = bus_rdata; bus_cpu = 2'd1;
        @(negedge clk);
        d1 = bus_rdata; bus_ren = 1'b0;
        check("R7 first reader wins", d0, 32'h0001_0003);
        check("R7 second reader empty", d1, 32'h0);
        wr(16'h0280, 32'h0000_0008);
    endtask

    task automatic t_level;
        logic [31:0] d;
        hw_irq[12] = 1'b1;
        irq_is("R3 masked line silent", 4'b0000);
        wr(16'h0180, 32'h0000_1000);
        irq_is("R8 unmasked line raises", 4'b0001);
        hw_irq[12] = 1'b0;
        irq_is("R9 drop clears irq", 4'b0000);
        rd(0, 16'h0004, d); check("R9 nothing to read", d, 32'h0);
        wr(16'h0100, 32'h0000_1000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_mask_bank();
        t_soft_trigger();
        t_priority();
        t_routing();
        t_shared_race();
        t_level();
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end
endmodule